// File: doc/BRIEF.md
# Processor Exception Entry Sequencer

This block decides which processor exception is taken and performs the entry step for it. Six request lines feed a fixed-priority arbiter: data abort, fast interrupt, normal interrupt, prefetch abort, software interrupt and undefined instruction. The synchronous reset acts as a seventh request above all of them. In the cycle an exception is accepted, the block writes the live status word into the saved-status register of the target mode. It writes a return address, derived from the current PC, into that mode's link register. It then rewrites the mode, state and mask bits of the status word and redirects the PC to the exception's vector slot.

The block also performs the matching return step. When the core asks to return, the block selects the saved-status bank of the current mode and restores the status word from it. It loads the PC from that bank's link value minus an adjustment that depends on which exception last filled the bank. The core may also load the status word directly, for example when it leaves supervisor mode after start-up. All results are registered.

Status word layout: bits [4:0] hold the mode (user 0x10, fast-interrupt 0x11, normal-interrupt 0x12, supervisor 0x13, abort 0x17, undefined 0x1B). Bit 5 is the compact-instruction state flag, bit 6 masks fast interrupts and bit 7 masks normal interrupts. All other bits are carried unchanged. The banks are indexed 0 fast-interrupt, 1 normal-interrupt, 2 supervisor, 3 abort, 4 undefined. Bank b occupies bits [b*W +: W] of the flattened bank outputs.

Top module: `exc_entry_seq`

## Requirements
- R1: While `rst` is high at a clock edge, `pc_o` becomes 0x0000 and `psr_o` becomes 0x000000D3 (supervisor mode, both masks set, state bit clear). `taken_o` and `ret_done_o` become 0, every saved-status and link bank becomes 0, and every bank's recorded exception becomes software interrupt.
- R2: Request bits are `req_i[0]` data abort, `[1]` fast interrupt, `[2]` normal interrupt, `[3]` prefetch abort, `[4]` software interrupt and `[5]` undefined. Among the unmasked asserted requests, the lowest bit index is taken, and `taken_code_o` reports that index.
- R3: On entry, `pc_o` becomes the vector: 0x04 undefined, 0x08 software interrupt, 0x0C prefetch abort, 0x10 data abort, 0x18 normal interrupt, 0x1C fast interrupt.
- R4: On entry, the status word before entry is stored in the target mode's saved-status bank. The link bank receives `cur_pc_i` + 8 for data abort and `cur_pc_i` + 4 for every other exception. No other bank changes.
- R5: On entry, the mode field becomes the target mode: abort for both aborts, fast-interrupt, normal-interrupt, supervisor for software interrupt, undefined for undefined. Bit 5 is cleared and bit 7 is set. Bit 6 is set for a fast interrupt and left unchanged otherwise. All other bits are kept.
- R6: A normal interrupt request is ignored while bit 7 is set, and a fast interrupt request is ignored while bit 6 is set. Abort, software interrupt and undefined requests are never masked.
- R7: Once a fast interrupt is taken, a held normal interrupt request is not accepted until a return restores a status word with bit 7 clear. It is then taken on the following cycle.
- R8: When `ret_i` is high, no request is taken, and the current mode has a bank, the status word is restored from that bank and `ret_done_o` pulses. The PC becomes the bank's link value minus the adjustment of the exception last entered into it: 8 for data abort, 4 for fast interrupt, normal interrupt and prefetch abort, 0 for software interrupt and undefined. In user mode `ret_i` has no effect.
- R9: At most one exception is taken per cycle, and `taken_o` pulses for one cycle. A request that is still asserted is evaluated again in the next cycle against the updated masks.
- R10: Entry takes precedence over return, and return takes precedence over `psr_wr_i`. `psr_wr_i` alone loads `psr_wdata_i` into the status word and leaves the PC unchanged. With no request, return or write, the PC and status word hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 6 | Exception request levels, bit order as in R2 |
| cur_pc_i | input | AW | PC of the instruction at which the exception is raised |
| psr_wr_i | input | 1 | Direct status word load strobe |
| psr_wdata_i | input | DW | Status word to load |
| ret_i | input | 1 | Return-from-exception request |
| pc_o | output | AW | Redirected program counter |
| psr_o | output | DW | Current status word |
| taken_o | output | 1 | One-cycle pulse: an exception was entered |
| taken_code_o | output | 3 | Index of the exception entered |
| ret_done_o | output | 1 | One-cycle pulse: a return was performed |
| spsr_banks_o | output | 5*DW | Saved-status banks, flattened |
| lr_banks_o | output | 5*AW | Link banks, flattened |

## Verification
On every cycle, the assertions check the post-reset values and that an asserted data abort always wins. They check the vector addresses of the fast interrupt and data abort, the state and mask bits forced on entry, and that neither interrupt is entered while its mask was set. They also check that entry and return never coincide and that the PC and status word hold when nothing is requested. The saved-status and link contents, the per-exception return adjustment, and the hand-over from a fast interrupt to a held normal interrupt after return span several cycles of history. These are shown only by the bench's reference model under directed and random sequences.

// File: rtl/exc_seq_pkg.sv
package exc_seq_pkg;

  localparam int NUM_EXC  = 6;
  localparam int NUM_BANK = 5;
  localparam int CODE_W   = 3;
  localparam int BANK_W   = 3;

  localparam int PSR_T = 5;
  localparam int PSR_F = 6;
  localparam int PSR_I = 7;

  localparam logic [4:0] MODE_USR = 5'h10;
  localparam logic [4:0] MODE_FIQ = 5'h11;
  localparam logic [4:0] MODE_IRQ = 5'h12;
  localparam logic [4:0] MODE_SVC = 5'h13;
  localparam logic [4:0] MODE_ABT = 5'h17;
  localparam logic [4:0] MODE_UND = 5'h1B;

  localparam logic [CODE_W-1:0] EXC_DABT = 3'd0;
  localparam logic [CODE_W-1:0] EXC_FIQ  = 3'd1;
  localparam logic [CODE_W-1:0] EXC_IRQ  = 3'd2;
  localparam logic [CODE_W-1:0] EXC_PABT = 3'd3;
  localparam logic [CODE_W-1:0] EXC_SWI  = 3'd4;
  localparam logic [CODE_W-1:0] EXC_UND  = 3'd5;

  typedef struct packed {
    logic [4:0]        mode;
    logic [7:0]        vec_off;
    logic [3:0]        lr_off;
    logic              fmask;
    logic [BANK_W-1:0] bank;
  } exc_attr_t;

  typedef struct packed {
    logic              hit;
    logic [BANK_W-1:0] idx;
  } bank_sel_t;

  function automatic bank_sel_t bank_of_mode(input logic [4:0] m);
    bank_sel_t s;
    s.hit = 1'b1;
    case (m)
      MODE_FIQ: s.idx = 3'd0;
      MODE_IRQ: s.idx = 3'd1;
      MODE_SVC: s.idx = 3'd2;
      MODE_ABT: s.idx = 3'd3;
      MODE_UND: s.idx = 3'd4;
      default: begin
        s.hit = 1'b0;
        s.idx = 3'd0;
      end
    endcase
    return s;
  endfunction

  function automatic logic [3:0] ret_adjust(input logic [CODE_W-1:0] c);
    case (c)
      EXC_DABT:                   return 4'd8;
      EXC_FIQ, EXC_IRQ, EXC_PABT: return 4'd4;
      default:                    return 4'd0;
    endcase
  endfunction

endpackage

// File: rtl/exc_prio_arb.sv
module exc_prio_arb #(
  parameter int N  = 6,
  parameter int CW = 3
) (
  input  logic [N-1:0]  req,
  input  logic [N-1:0]  mask,
  output logic          valid,
  output logic [CW-1:0] code
);

  logic [N-1:0] elig;
  logic [N-1:0] grant;
  logic [N:0]   seen;

  assign elig    = req & ~mask;
  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_chain
    assign grant[i]  = elig[i] & ~seen[i];
    assign seen[i+1] = seen[i] | elig[i];
  end

  assign valid = seen[N];

  always_comb begin
    code = '0;
    for (int i = 0; i < N; i++) begin
      if (grant[i]) code = code | CW'(i);
    end
  end

endmodule

// File: rtl/exc_attr_map.sv
module exc_attr_map
  import exc_seq_pkg::*;
(
  input  logic [CODE_W-1:0] code,
  output exc_attr_t         attr
);

  always_comb begin
    attr = '0;
    case (code)
      EXC_DABT: begin attr.mode = MODE_ABT; attr.vec_off = 8'h10; attr.lr_off = 4'd8; attr.bank = 3'd3; end
      EXC_FIQ:  begin attr.mode = MODE_FIQ; attr.vec_off = 8'h1C; attr.lr_off = 4'd4; attr.bank = 3'd0;
                      attr.fmask = 1'b1; end
      EXC_IRQ:  begin attr.mode = MODE_IRQ; attr.vec_off = 8'h18; attr.lr_off = 4'd4; attr.bank = 3'd1; end
      EXC_PABT: begin attr.mode = MODE_ABT; attr.vec_off = 8'h0C; attr.lr_off = 4'd4; attr.bank = 3'd3; end
      EXC_SWI:  begin attr.mode = MODE_SVC; attr.vec_off = 8'h08; attr.lr_off = 4'd4; attr.bank = 3'd2; end
      default:  begin attr.mode = MODE_UND; attr.vec_off = 8'h04; attr.lr_off = 4'd4; attr.bank = 3'd4; end
    endcase
  end

endmodule

// File: rtl/exc_bank_file.sv
module exc_bank_file
  import exc_seq_pkg::*;
#(
  parameter int NB = 5,
  parameter int DW = 32,
  parameter int AW = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [BANK_W-1:0] wr_idx,
  input  logic [DW-1:0]     wr_spsr,
  input  logic [AW-1:0]     wr_lr,
  input  logic [CODE_W-1:0] wr_kind,
  input  logic [BANK_W-1:0] rd_idx,
  output logic [DW-1:0]     rd_spsr,
  output logic [AW-1:0]     rd_lr,
  output logic [CODE_W-1:0] rd_kind,
  output logic [NB*DW-1:0]  spsr_flat,
  output logic [NB*AW-1:0]  lr_flat
);

  logic [NB*CODE_W-1:0] kind_flat;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic [DW-1:0]     spsr_r;
    logic [AW-1:0]     lr_r;
    logic [CODE_W-1:0] kind_r;

    always_ff @(posedge clk) begin
      if (rst) begin
        spsr_r <= '0;
        lr_r   <= '0;
        kind_r <= EXC_SWI;
      end else if (wr_en && wr_idx == BANK_W'(b)) begin
        spsr_r <= wr_spsr;
        lr_r   <= wr_lr;
        kind_r <= wr_kind;
      end
    end

    assign spsr_flat[b*DW +: DW]         = spsr_r;
    assign lr_flat[b*AW +: AW]           = lr_r;
    assign kind_flat[b*CODE_W +: CODE_W] = kind_r;
  end

  always_comb begin
    rd_spsr = '0;
    rd_lr   = '0;
    rd_kind = '0;
    for (int b = 0; b < NB; b++) begin
      if (rd_idx == BANK_W'(b)) begin
        rd_spsr = spsr_flat[b*DW +: DW];
        rd_lr   = lr_flat[b*AW +: AW];
        rd_kind = kind_flat[b*CODE_W +: CODE_W];
      end
    end
  end

endmodule

// File: rtl/exc_entry_seq.sv
module exc_entry_seq
  import exc_seq_pkg::*;
#(
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [NUM_EXC-1:0]     req_i,
  input  logic [AW-1:0]          cur_pc_i,
  input  logic                   psr_wr_i,
  input  logic [DW-1:0]          psr_wdata_i,
  input  logic                   ret_i,
  output logic [AW-1:0]          pc_o,
  output logic [DW-1:0]          psr_o,
  output logic                   taken_o,
  output logic [CODE_W-1:0]      taken_code_o,
  output logic                   ret_done_o,
  output logic [NUM_BANK*DW-1:0] spsr_banks_o,
  output logic [NUM_BANK*AW-1:0] lr_banks_o
);

  localparam logic [AW-1:0] BASE     = AW'(VEC_BASE);
  localparam logic [DW-1:0] PSR_RST  = DW'({1'b1, 1'b1, 1'b0, MODE_SVC});

  logic [AW-1:0]      pc_q;
  logic [DW-1:0]      psr_q;
  logic [NUM_EXC-1:0] mask;
  logic               take;
  logic [CODE_W-1:0]  code;
  exc_attr_t          attr;
  bank_sel_t          cur_bank;
  logic [DW-1:0]      rd_spsr;
  logic [AW-1:0]      rd_lr;
  logic [CODE_W-1:0]  rd_kind;
  logic [DW-1:0]      psr_entry;
  logic               do_ret;

  always_comb begin
    mask           = '0;
    mask[EXC_FIQ]  = psr_q[PSR_F];
    mask[EXC_IRQ]  = psr_q[PSR_I];
  end

  exc_prio_arb #(.N(NUM_EXC), .CW(CODE_W)) u_arb (
    .req   (req_i),
    .mask  (mask),
    .valid (take),
    .code  (code)
  );

  exc_attr_map u_attr (
    .code (code),
    .attr (attr)
  );

  assign cur_bank = bank_of_mode(psr_q[4:0]);
  assign do_ret   = ret_i && cur_bank.hit;

  exc_bank_file #(.NB(NUM_BANK), .DW(DW), .AW(AW)) u_banks (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (take),
    .wr_idx    (attr.bank),
    .wr_spsr   (psr_q),
    .wr_lr     (cur_pc_i + AW'(attr.lr_off)),
    .wr_kind   (code),
    .rd_idx    (cur_bank.idx),
    .rd_spsr   (rd_spsr),
    .rd_lr     (rd_lr),
    .rd_kind   (rd_kind),
    .spsr_flat (spsr_banks_o),
    .lr_flat   (lr_banks_o)
  );

  always_comb begin
    psr_entry        = psr_q;
    psr_entry[4:0]   = attr.mode;
    psr_entry[PSR_T] = 1'b0;
    psr_entry[PSR_I] = 1'b1;
    if (attr.fmask) psr_entry[PSR_F] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q         <= BASE;
      psr_q        <= PSR_RST;
      taken_o      <= 1'b0;
      taken_code_o <= '0;
      ret_done_o   <= 1'b0;
    end else begin
      taken_o    <= 1'b0;
      ret_done_o <= 1'b0;
      if (take) begin
        pc_q         <= BASE + AW'(attr.vec_off);
        psr_q        <= psr_entry;
        taken_o      <= 1'b1;
        taken_code_o <= code;
      end else if (do_ret) begin
        pc_q       <= rd_lr - AW'(ret_adjust(rd_kind));
        psr_q      <= rd_spsr;
        ret_done_o <= 1'b1;
      end else if (psr_wr_i) begin
        psr_q <= psr_wdata_i;
      end
    end
  end

  assign pc_o  = pc_q;
  assign psr_o = psr_q;

endmodule

// File: rtl/exc_entry_seq_chk.sv
module exc_entry_seq_chk #(
  parameter int          DW       = 32,
  parameter int          AW       = 32,
  parameter logic [31:0] VEC_BASE = 32'h0
) (
  input logic          clk,
  input logic          rst,
  input logic [5:0]    req_i,
  input logic          ret_i,
  input logic          psr_wr_i,
  input logic [AW-1:0] pc_o,
  input logic [DW-1:0] psr_o,
  input logic          taken_o,
  input logic [2:0]    taken_code_o,
  input logic          ret_done_o
);

  localparam logic [AW-1:0] BASE = AW'(VEC_BASE);

  p_reset_state_r1: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (pc_o == BASE && psr_o[7:0] == 8'hD3 && !taken_o && !ret_done_o));

  p_dabt_wins_r2: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_i[0])) |-> (taken_o && taken_code_o == 3'd0));

  p_dabt_vector_r3: assert property (@(posedge clk) disable iff (rst)
    (taken_o && taken_code_o == 3'd0) |-> pc_o == BASE + AW'(32'h10));

  p_fiq_vector_r3: assert property (@(posedge clk) disable iff (rst)
    (taken_o && taken_code_o == 3'd1) |-> pc_o == BASE + AW'(32'h1C));

  p_entry_bits_r5: assert property (@(posedge clk) disable iff (rst)
    taken_o |-> (!psr_o[5] && psr_o[7]));

  p_fiq_sets_f_r5: assert property (@(posedge clk) disable iff (rst)
    (taken_o && taken_code_o == 3'd1) |-> psr_o[6]);

  p_irq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (taken_o && taken_code_o == 3'd2) |-> !$past(psr_o[7]));

  p_fiq_masked_r6: assert property (@(posedge clk) disable iff (rst)
    (taken_o && taken_code_o == 3'd1) |-> !$past(psr_o[6]));

  p_single_event_r9: assert property (@(posedge clk) disable iff (rst)
    !(taken_o && ret_done_o));

  p_idle_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(req_i) == 6'd0 && !$past(ret_i) && !$past(psr_wr_i))
      |-> ($stable(pc_o) && $stable(psr_o)));

endmodule

bind exc_entry_seq exc_entry_seq_chk #(.DW(DW), .AW(AW), .VEC_BASE(VEC_BASE)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_i        (req_i),
  .ret_i        (ret_i),
  .psr_wr_i     (psr_wr_i),
  .pc_o         (pc_o),
  .psr_o        (psr_o),
  .taken_o      (taken_o),
  .taken_code_o (taken_code_o),
  .ret_done_o   (ret_done_o)
);

// File: tb/exc_entry_seq_bench.sv
module exc_entry_seq_bench;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [5:0]   req_i = '0;
  logic [31:0]  cur_pc_i = '0;
  logic         psr_wr_i = 1'b0;
  logic [31:0]  psr_wdata_i = '0;
  logic         ret_i = 1'b0;
  logic [31:0]  pc_o;
  logic [31:0]  psr_o;
  logic         taken_o;
  logic [2:0]   taken_code_o;
  logic         ret_done_o;
  logic [159:0] spsr_banks_o;
  logic [159:0] lr_banks_o;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  exc_entry_seq u_exc_entry_seq (
    .clk(clk), .rst(rst), .req_i(req_i), .cur_pc_i(cur_pc_i),
    .psr_wr_i(psr_wr_i), .psr_wdata_i(psr_wdata_i), .ret_i(ret_i),
    .pc_o(pc_o), .psr_o(psr_o), .taken_o(taken_o), .taken_code_o(taken_code_o),
    .ret_done_o(ret_done_o), .spsr_banks_o(spsr_banks_o), .lr_banks_o(lr_banks_o)
  );

  bit [31:0] m_pc, m_psr;
  bit [31:0] m_spsr [5];
  bit [31:0] m_lr [5];
  int        m_kind [5];
  bit        m_tk, m_rt;
  bit [2:0]  m_code;

  function automatic int bmode(bit [4:0] m);
    case (m)
      5'h11: return 0;
      5'h12: return 1;
      5'h13: return 2;
      5'h17: return 3;
      5'h1B: return 4;
      default: return -1;
    endcase
  endfunction

  function automatic bit [31:0] vec_of(int c);
    case (c)
      0: return 32'h10; 1: return 32'h1C; 2: return 32'h18;
      3: return 32'h0C; 4: return 32'h08; default: return 32'h04;
    endcase
  endfunction

  function automatic bit [4:0] mode_of(int c);
    case (c)
      0, 3: return 5'h17; 1: return 5'h11; 2: return 5'h12;
      4: return 5'h13; default: return 5'h1B;
    endcase
  endfunction

  function automatic bit [31:0] adj_of(int c);
    case (c)
      0: return 32'd8; 1, 2, 3: return 32'd4; default: return 32'd0;
    endcase
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    m_pc = 32'h0; m_psr = 32'hD3; m_tk = 0; m_rt = 0; m_code = 0;
    for (int b = 0; b < 5; b++) begin
      m_spsr[b] = 0; m_lr[b] = 0; m_kind[b] = 4;
    end
  endtask

  task automatic model_step(bit [5:0] rq, bit rt, bit wr, bit [31:0] wd, bit [31:0] cpc);
    bit [5:0] el;
    int c, b;
    el = rq;
    if (m_psr[7]) el[2] = 1'b0;
    if (m_psr[6]) el[1] = 1'b0;
    m_tk = 0; m_rt = 0;
    if (el != 0) begin
      c = 0;
      while (!el[c]) c++;
      b = bmode(mode_of(c));
      m_spsr[b] = m_psr;
      m_lr[b]   = cpc + ((c == 0) ? 32'd8 : 32'd4);
      m_kind[b] = c;
      m_psr[4:0] = mode_of(c);
      m_psr[5] = 1'b0;
      m_psr[7] = 1'b1;
      if (c == 1) m_psr[6] = 1'b1;
      m_pc = vec_of(c);
      m_tk = 1; m_code = 3'(c);
    end else if (rt && bmode(m_psr[4:0]) >= 0) begin
      b = bmode(m_psr[4:0]);
      m_pc  = m_lr[b] - adj_of(m_kind[b]);
      m_psr = m_spsr[b];
      m_rt  = 1;
    end else if (wr) begin
      m_psr = wd;
    end
  endtask

  task automatic compare_all();
    string tpc;
    tpc = m_tk ? "R3 vector" : (m_rt ? "R8 return pc" : "R10 pc hold");
    chk(taken_o == m_tk, "R9 taken pulse", 32'(taken_o), 32'(m_tk));
    if (m_tk) chk(taken_code_o == m_code, "R2 priority code", 32'(taken_code_o), 32'(m_code));
    chk(ret_done_o == m_rt, "R8 return pulse", 32'(ret_done_o), 32'(m_rt));
    chk(pc_o == m_pc, tpc, pc_o, m_pc);
    chk(psr_o == m_psr, m_tk ? "R5 entry status" : (m_rt ? "R8 restore status" : "R10 status"), psr_o, m_psr);
    for (int b = 0; b < 5; b++) begin
      chk(spsr_banks_o[b*32 +: 32] == m_spsr[b], "R4 saved status bank", spsr_banks_o[b*32 +: 32], m_spsr[b]);
      chk(lr_banks_o[b*32 +: 32] == m_lr[b], "R4 link bank", lr_banks_o[b*32 +: 32], m_lr[b]);
    end
  endtask

  task automatic cyc(bit [5:0] rq, bit rt, bit wr, bit [31:0] wd, bit [31:0] cpc);
    req_i = rq; ret_i = rt; psr_wr_i = wr; psr_wdata_i = wd; cur_pc_i = cpc;
    model_step(rq, rt, wr, wd, cpc);
    @(posedge clk);
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0x%08h expected 0x%08h", 32'd1, 32'd0);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    bit [4:0] modes [6];
    bit [31:0] w;
    bit [5:0] rq;
    modes = '{5'h10, 5'h11, 5'h12, 5'h13, 5'h17, 5'h1B};
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    model_reset();
    // R1: reset values at the ports
    chk(pc_o == 32'h0, "R1 reset pc", pc_o, 32'h0);
    chk(psr_o == 32'hD3, "R1 reset status", psr_o, 32'hD3);
    chk(taken_o == 1'b0, "R1 reset taken", 32'(taken_o), 32'h0);
    chk(spsr_banks_o == '0 && lr_banks_o == '0, "R1 reset banks", spsr_banks_o[31:0], 32'h0);

    // R6: interrupts masked by the reset status
    cyc(6'b000110, 0, 0, 0, 32'h100);
    chk(taken_o == 1'b0, "R6 masked interrupts ignored", 32'(taken_o), 32'h0);
    // R8: return from user mode has no effect
    cyc(6'b0, 0, 1, 32'h0000_0010, 32'h100);
    cyc(6'b0, 1, 0, 0, 32'h104);
    chk(ret_done_o == 1'b0 && pc_o == 32'h0, "R8 return ignored in user mode", pc_o, 32'h0);
    // R2/R7: fast wins over normal, normal held off until return
    cyc(6'b000110, 0, 0, 0, 32'h200);
    chk(taken_code_o == 3'd1, "R2 fast beats normal", 32'(taken_code_o), 32'd1);
    cyc(6'b000100, 0, 0, 0, 32'h1C);
    chk(taken_o == 1'b0, "R7 normal held during fast handler", 32'(taken_o), 32'h0);
    cyc(6'b000100, 1, 0, 0, 32'h20);
    chk(pc_o == 32'h200 && psr_o == 32'h10, "R7 fast return restores user", pc_o, 32'h200);
    cyc(6'b000100, 0, 0, 0, 32'h200);
    chk(taken_o && taken_code_o == 3'd2, "R7 normal taken after return", 32'(taken_code_o), 32'd2);
    // R10: entry beats return and status write
    cyc(6'b010000, 1, 1, 32'h10, 32'h300);
    chk(taken_code_o == 3'd4 && psr_o[4:0] == 5'h13, "R10 entry precedence", psr_o, 32'h13);
    // R9: held lower request evaluated next cycle
    cyc(6'b101000, 0, 0, 0, 32'h400);
    cyc(6'b100000, 0, 0, 0, 32'h404);
    chk(taken_code_o == 3'd5, "R9 lower request next cycle", 32'(taken_code_o), 32'd5);
    // R8: data abort return adjustment
    cyc(6'b000001, 0, 0, 0, 32'h500);
    cyc(6'b0, 1, 0, 0, 32'h10);
    chk(pc_o == 32'h500, "R8 data abort return", pc_o, 32'h500);

    for (int i = 0; i < 1500; i++) begin
      rq = '0;
      for (int k = 0; k < 6; k++) rq[k] = ($urandom % 9) == 0;
      w = $urandom;
      w[4:0] = modes[$urandom % 6];
      cyc(rq, ($urandom % 5) == 0, ($urandom % 8) == 0, w, $urandom & 32'hFFFF_FFFC);
    end

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule